// File: doc/BRIEF.md
# Hardware Cursor Overlay Generator

This block paints a 64 by 64 pointer image over a raster pixel stream. Each cursor pixel is a two-bit code kept in a 1024-byte pattern memory, four codes per byte. The host loads that memory through a pointer and a data port, picks one of four code interpretations, and places the image with 12-bit X and Y coordinates. Each coordinate is written as two bytes.

For every pixel presented with its raster coordinates and base color, the block returns one of three things: the base color, one of three cursor colors supplied on input pins, or the bitwise complement of the base color. The programmed coordinate names the lower-right pixel of the image. A coordinate of zero on either axis removes the image completely. New coordinates are staged and only go live on a frame-start pulse, so a moving pointer is never split across two positions within one frame.

Top module: `cursor_overlay`

## Requirements
- R1: After the synchronous reset, out_valid and out_pix are zero, the live position is zero and the effective mode is off.
- R2: A pixel presented with pix_valid high appears on out_pix with out_valid high after exactly two rising clock edges. out_valid is still low after the first edge and stays low for cycles with pix_valid low.
- R3: With live position (X, Y), a pixel is covered only when X-63 <= pix_x <= X and Y-63 <= pix_y <= Y. Its column within the image is pix_x-(X-63) and its row is pix_y-(Y-63).
- R4: When the live X or the live Y is zero, every pixel leaves with its base color.
- R5: host_sel 2 writes the direct mode (bits 1:0). host_sel 3 writes the auxiliary control: bit 7 set selects the direct mode, bit 7 clear selects aux bits 1:0 as the mode. Mode 0 (off) passes the base color.
- R6: The pattern pointer is 10 bits. host_sel 3 loads its top two bits from data bits 3:2 and host_sel 0 loads its low eight bits. Each write on host_sel 1 stores the byte and then advances the pointer by one, wrapping from 1023 to 0.
- R7: The byte at address row*16 + column/4 holds four adjacent columns, with bits 7:6 for the leftmost column and bits 1:0 for the rightmost.
- R8: Mode 1: code 00 is transparent, and codes 01, 10 and 11 give color0, color1 and color2.
- R9: Mode 2: code 00 gives color0, 01 gives color1, 10 is transparent, and 11 gives the complement of the base color.
- R10: Mode 3: codes 00 and 01 are transparent, 10 gives color0 and 11 gives color1.
- R11: host_sel 4 and 6 write the low bytes of X and Y. host_sel 5 and 7 write their top four bits from data bits 3:0. These writes are staged and become live only on a cycle with frame_start high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Host register select |
| host_wdata | input | 8 | Host write byte |
| frame_start | input | 1 | Pulse between frames; makes staged position live |
| pix_valid | input | 1 | Pixel present on this cycle |
| pix_x | input | 12 | Raster column of the pixel |
| pix_y | input | 12 | Raster row of the pixel |
| pix_base | input | 24 | Underlying pixel color |
| color0 | input | 24 | First cursor color |
| color1 | input | 24 | Second cursor color |
| color2 | input | 24 | Third cursor color |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 24 | Overlaid pixel color |

## Verification
A wrong pattern pointer or a wrong bit-pair choice shows up as a wrong color at one particular column of the image, two cycles after that pixel goes in. A uniform 00-01-10-11 fill makes a one-column shift visible at every edge of the image. An error in the window arithmetic shows as a colored pixel just outside the 64-pixel span, or as a base-colored pixel at the corner. A staging error shows as the image moving before the frame-start pulse. Each of these is visible on the very next pixel that lands on the affected spot.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  typedef enum logic [1:0] {
    CM_OFF = 2'd0,
    CM_TRI = 2'd1,
    CM_XOR = 2'd2,
    CM_WIN = 2'd3
  } cmode_t;

  localparam logic [2:0] SEL_ADDR = 3'd0;
  localparam logic [2:0] SEL_DATA = 3'd1;
  localparam logic [2:0] SEL_MODE = 3'd2;
  localparam logic [2:0] SEL_AUX  = 3'd3;
  localparam logic [2:0] SEL_XLO  = 3'd4;
  localparam logic [2:0] SEL_XHI  = 3'd5;
  localparam logic [2:0] SEL_YLO  = 3'd6;
  localparam logic [2:0] SEL_YHI  = 3'd7;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int PW = 12,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [2:0]    host_sel,
  input  logic [7:0]    host_wdata,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output cmode_t        mode,
  output logic [PW-1:0] stage_x,
  output logic [PW-1:0] stage_y
);
  localparam int HI = AW - 8;

  logic [AW-1:0] addr;
  logic [1:0]    dmode, imode;
  logic          use_direct;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr       <= '0;
      dmode      <= 2'd0;
      imode      <= 2'd0;
      use_direct <= 1'b0;
      stage_x    <= '0;
      stage_y    <= '0;
    end else if (host_we) begin
      case (host_sel)
        SEL_ADDR: addr[7:0] <= host_wdata;
        SEL_DATA: addr <= addr + 1'b1;
        SEL_MODE: dmode <= host_wdata[1:0];
        SEL_AUX: begin
          use_direct   <= host_wdata[7];
          imode        <= host_wdata[1:0];
          addr[AW-1:8] <= host_wdata[2 +: HI];
        end
        SEL_XLO: stage_x[7:0]    <= host_wdata;
        SEL_XHI: stage_x[PW-1:8] <= host_wdata[PW-9:0];
        SEL_YLO: stage_y[7:0]    <= host_wdata;
        default: stage_y[PW-1:8] <= host_wdata[PW-9:0];
      endcase
    end
  end

  assign ram_we    = host_we && (host_sel == SEL_DATA);
  assign ram_addr  = addr;
  assign ram_wdata = host_wdata;
  assign mode      = cmode_t'(use_direct ? dmode : imode);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> (ram_addr == AW'($past(ram_addr) + 1'b1)));
endmodule

// File: rtl/cursor_ram.sv
module cursor_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cursor_hit.sv
module cursor_hit #(
  parameter int PW  = 12,
  parameter int LOG = 6,
  parameter int AW  = 2 * LOG - 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic [PW-1:0] stage_x,
  input  logic [PW-1:0] stage_y,
  input  logic          pix_valid,
  input  logic [PW-1:0] pix_x,
  input  logic [PW-1:0] pix_y,
  output logic [AW-1:0] rd_addr,
  output logic          s_valid,
  output logic          s_hit,
  output logic [1:0]    s_sub
);
  localparam int          SZ  = 1 << LOG;
  localparam logic [PW:0] OFS = PW'(SZ - 1);

  logic [PW-1:0]  act_x, act_y;
  logic [PW:0]    ex, ey;
  logic           in_x, in_y;
  logic [LOG-1:0] dx, dy;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_x <= '0;
      act_y <= '0;
    end else if (frame_start) begin
      act_x <= stage_x;
      act_y <= stage_y;
    end
  end

  always_comb begin
    ex   = {1'b0, pix_x} + OFS;
    ey   = {1'b0, pix_y} + OFS;
    in_x = (ex >= {1'b0, act_x}) && (pix_x <= act_x);
    in_y = (ey >= {1'b0, act_y}) && (pix_y <= act_y);
    dx   = LOG'(ex - {1'b0, act_x});
    dy   = LOG'(ey - {1'b0, act_y});
  end

  assign rd_addr = {dy, dx[LOG-1:2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_hit   <= 1'b0;
      s_sub   <= 2'd0;
    end else begin
      s_valid <= pix_valid;
      s_hit   <= pix_valid && in_x && in_y && (act_x != '0) && (act_y != '0);
      s_sub   <= dx[1:0];
    end
  end

  assert_hold_pos_R11: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> (act_x == $past(act_x)) && (act_y == $past(act_y)));
  assert_zero_hide_R4: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && (act_x == '0 || act_y == '0)) |=> !s_hit);
  assert_right_edge_R3: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && (pix_x > act_x)) |=> !s_hit);
endmodule

// File: rtl/cursor_mix.sv
module cursor_mix
  import cursor_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] pix_base,
  input  cmode_t        mode,
  input  logic          s_valid,
  input  logic          s_hit,
  input  logic [1:0]    s_sub,
  input  logic [7:0]    s_byte,
  input  logic [CW-1:0] color0,
  input  logic [CW-1:0] color1,
  input  logic [CW-1:0] color2,
  output logic          out_valid,
  output logic [CW-1:0] out_pix
);
  logic [CW-1:0] s_base;
  cmode_t        s_mode;
  logic [2:0]    lsb;
  logic [1:0]    code;
  logic [CW-1:0] drawn;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_base <= '0;
      s_mode <= CM_OFF;
    end else begin
      s_base <= pix_base;
      s_mode <= mode;
    end
  end

  always_comb begin
    lsb   = 3'd6 - {s_sub, 1'b0};
    code  = s_byte[lsb +: 2];
    drawn = s_base;
    case (s_mode)
      CM_TRI: case (code)
        2'b01:   drawn = color0;
        2'b10:   drawn = color1;
        2'b11:   drawn = color2;
        default: drawn = s_base;
      endcase
      CM_XOR: case (code)
        2'b00:   drawn = color0;
        2'b01:   drawn = color1;
        2'b11:   drawn = ~s_base;
        default: drawn = s_base;
      endcase
      CM_WIN: case (code)
        2'b10:   drawn = color0;
        2'b11:   drawn = color1;
        default: drawn = s_base;
      endcase
      default: drawn = s_base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= s_valid;
      out_pix   <= s_hit ? drawn : s_base;
    end
  end

  assert_off_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_mode == CM_OFF) |=> (out_pix == $past(s_base)));
  assert_tri_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_hit && s_mode == CM_TRI && code == 2'b00) |=> (out_pix == $past(s_base)));
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int PW  = 12,
  parameter int CW  = 24,
  parameter int LOG = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [2:0]    host_sel,
  input  logic [7:0]    host_wdata,
  input  logic          frame_start,
  input  logic          pix_valid,
  input  logic [PW-1:0] pix_x,
  input  logic [PW-1:0] pix_y,
  input  logic [CW-1:0] pix_base,
  input  logic [CW-1:0] color0,
  input  logic [CW-1:0] color1,
  input  logic [CW-1:0] color2,
  output logic          out_valid,
  output logic [CW-1:0] out_pix
);
  localparam int AW = 2 * LOG - 2;

  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [7:0]    ram_wdata, ram_rdata;
  cmode_t        mode;
  logic [PW-1:0] stage_x, stage_y;
  logic          s_valid, s_hit;
  logic [1:0]    s_sub;

  cursor_regs #(.PW(PW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .ram_we(ram_we), .ram_addr(ram_waddr),
    .ram_wdata(ram_wdata), .mode(mode), .stage_x(stage_x), .stage_y(stage_y)
  );

  cursor_hit #(.PW(PW), .LOG(LOG), .AW(AW)) u_hit (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .stage_x(stage_x), .stage_y(stage_y), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .rd_addr(ram_raddr),
    .s_valid(s_valid), .s_hit(s_hit), .s_sub(s_sub)
  );

  cursor_ram #(.AW(AW), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  cursor_mix #(.CW(CW)) u_mix (
    .clk(clk), .rst(rst), .pix_base(pix_base), .mode(mode),
    .s_valid(s_valid), .s_hit(s_hit), .s_sub(s_sub), .s_byte(ram_rdata),
    .color0(color0), .color1(color1), .color2(color2),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> ##2 out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> ##2 !out_valid);
endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
  import cursor_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [23:0] BASE = 24'h123456;
  localparam logic [23:0] C0   = 24'hAA0000;
  localparam logic [23:0] C1   = 24'h00BB00;
  localparam logic [23:0] C2   = 24'h0000CC;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        rst, host_we, frame_start, pix_valid, out_valid;
  logic [2:0]  host_sel;
  logic [7:0]  host_wdata;
  logic [11:0] pix_x, pix_y;
  logic [23:0] pix_base, out_pix;

  int checks = 0;
  int errors = 0;

  cursor_overlay u_cursor_overlay (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .pix_base(pix_base),
    .color0(C0), .color1(C1), .color2(C2),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  // kind: 0 base, 1 color0, 2 color1, 3 color2, 4 complement
  function automatic logic [23:0] kcol(input logic [2:0] k);
    case (k)
      3'd1:    return C0;
      3'd2:    return C1;
      3'd3:    return C2;
      3'd4:    return ~BASE;
      default: return BASE;
    endcase
  endfunction

  // {mode[2], px[12], py[12], kind[3], req[4]}; image at X=100, Y=200
  localparam int NV = 24;
  localparam logic [32:0] VEC [NV] = '{
    {2'd1, 12'd37,  12'd200, 3'd0, 4'd8},   // R8
    {2'd1, 12'd38,  12'd200, 3'd1, 4'd8},   // R8
    {2'd1, 12'd39,  12'd200, 3'd2, 4'd8},   // R8
    {2'd1, 12'd40,  12'd200, 3'd3, 4'd8},   // R8
    {2'd2, 12'd37,  12'd200, 3'd1, 4'd9},   // R9
    {2'd2, 12'd38,  12'd200, 3'd2, 4'd9},   // R9
    {2'd2, 12'd39,  12'd200, 3'd0, 4'd9},   // R9
    {2'd2, 12'd40,  12'd200, 3'd4, 4'd9},   // R9
    {2'd3, 12'd37,  12'd200, 3'd0, 4'd10},  // R10
    {2'd3, 12'd38,  12'd200, 3'd0, 4'd10},  // R10
    {2'd3, 12'd39,  12'd200, 3'd1, 4'd10},  // R10
    {2'd3, 12'd40,  12'd200, 3'd2, 4'd10},  // R10
    {2'd0, 12'd40,  12'd200, 3'd0, 4'd5},   // R5
    {2'd1, 12'd36,  12'd200, 3'd0, 4'd3},   // R3
    {2'd1, 12'd101, 12'd200, 3'd0, 4'd3},   // R3
    {2'd1, 12'd100, 12'd200, 3'd3, 4'd3},   // R3
    {2'd1, 12'd40,  12'd136, 3'd0, 4'd3},   // R3
    {2'd1, 12'd40,  12'd201, 3'd0, 4'd3},   // R3
    {2'd1, 12'd40,  12'd138, 3'd3, 4'd3},   // R3
    {2'd1, 12'd40,  12'd137, 3'd0, 4'd6},   // R6 wrap rewrote byte 0
    {2'd1, 12'd42,  12'd137, 3'd1, 4'd6},   // R6
    {2'd1, 12'd45,  12'd142, 3'd3, 4'd7},   // R7 byte 82 = FF
    {2'd1, 12'd60,  12'd169, 3'd0, 4'd6},   // R6 byte 0x205 = 00
    {2'd1, 12'd62,  12'd169, 3'd1, 4'd6}    // R6
  };

  task automatic chk(input logic ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic fs();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic pix(input logic [11:0] x, input logic [11:0] y,
                     output logic [23:0] res, output logic v1, output logic v2);
    @(negedge clk);
    pix_valid = 1'b1; pix_x = x; pix_y = y; pix_base = BASE;
    @(negedge clk);
    pix_valid = 1'b0;
    v1 = out_valid;
    @(negedge clk);
    v2 = out_valid;
    res = out_pix;
  endtask

  task automatic place(input logic [11:0] x, input logic [11:0] y);
    hw(SEL_XLO, x[7:0]); hw(SEL_XHI, {4'd0, x[11:8]});
    hw(SEL_YLO, y[7:0]); hw(SEL_YHI, {4'd0, y[11:8]});
    fs();
  endtask

  logic [23:0] r;
  logic v1, v2;

  initial begin
    rst = 1'b1; host_we = 1'b0; host_sel = '0; host_wdata = '0;
    frame_start = 1'b0; pix_valid = 1'b0; pix_x = '0; pix_y = '0; pix_base = BASE;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", {23'd0, out_valid}, 24'd0);
    chk(out_pix == '0, "R1 out_pix after reset", out_pix, 24'd0);
    pix(12'd0, 12'd0, r, v1, v2);
    chk(r == BASE, "R1 nothing drawn after reset", r, BASE);

    // pattern: every byte 00_01_10_11, then wrap, then two spot edits
    hw(SEL_AUX, 8'h80);
    hw(SEL_ADDR, 8'h00);
    for (int i = 0; i < 1024; i++) hw(SEL_DATA, 8'h1B);
    hw(SEL_DATA, 8'h00);
    hw(SEL_ADDR, 8'd82);
    hw(SEL_DATA, 8'hFF);
    hw(SEL_AUX, 8'h88);
    hw(SEL_ADDR, 8'h05);
    hw(SEL_DATA, 8'h00);
    hw(SEL_AUX, 8'h80);
    place(12'd100, 12'd200);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] e;
      e = VEC[i];
      hw(SEL_MODE, {6'd0, e[32:31]});
      pix(e[30:19], e[18:7], r, v1, v2);
      chk(r == kcol(e[6:4]), $sformatf("R%0d vector %0d", e[3:0], i), r, kcol(e[6:4]));
    end

    // R2 timing
    hw(SEL_MODE, 8'd1);
    pix(12'd40, 12'd200, r, v1, v2);
    chk(v1 == 1'b0, "R2 not valid after one edge", {23'd0, v1}, 24'd0);
    chk(v2 == 1'b1, "R2 valid after two edges", {23'd0, v2}, 24'd1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2 idle cycle not valid", {23'd0, out_valid}, 24'd0);

    // R5 source select: indexed mode 1 while direct holds 2
    hw(SEL_MODE, 8'd2);
    hw(SEL_AUX, 8'h01);
    pix(12'd40, 12'd200, r, v1, v2);
    chk(r == C2, "R5 aux mode governs when bit7 clear", r, C2);
    hw(SEL_AUX, 8'h00);
    pix(12'd40, 12'd200, r, v1, v2);
    chk(r == BASE, "R5 aux mode off", r, BASE);
    hw(SEL_AUX, 8'h80);
    pix(12'd40, 12'd200, r, v1, v2);
    chk(r == ~BASE, "R5 direct mode governs when bit7 set", r, ~BASE);

    // R11 staging, R4 zero hides
    hw(SEL_MODE, 8'd1);
    hw(SEL_XLO, 8'd0);
    pix(12'd40, 12'd200, r, v1, v2);
    chk(r == C2, "R11 staged X not yet live", r, C2);
    fs();
    pix(12'd40, 12'd200, r, v1, v2);
    chk(r == BASE, "R11 X live after frame start", r, BASE);
    pix(12'd0, 12'd200, r, v1, v2);
    chk(r == BASE, "R4 X zero hides image", r, BASE);
    place(12'd100, 12'd0);
    pix(12'd40, 12'd0, r, v1, v2);
    chk(r == BASE, "R4 Y zero hides image", r, BASE);

    // R11 high byte: X = 0x105
    place(12'h105, 12'd200);
    pix(12'd201, 12'd200, r, v1, v2);
    chk(r == C2, "R11 high byte of X", r, C2);
    pix(12'd197, 12'd200, r, v1, v2);
    chk(r == BASE, "R11 left of image with high byte", r, BASE);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R2 actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule